// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the calendar of a real-time clock as packed BCD values: seconds, minutes, hours, day of month, month and a two-digit year, plus a binary weekday. A base-rate `tick` pulse drives an internal sub-second prescaler. Every `TICK_DIV` pulses the seconds step by one, and carries ripple up through minutes, hours, days, months and years. The day rollover follows the month lengths and a leap year every fourth year.

Software reaches the calendar through a byte-wide register port. A write takes effect on the clock edge where `wrEn` is high. Reads are combinational from `addr`. One control byte holds a run/stop bit and a 12-hour display bit. Writing the control byte with one particular three-bit pattern resets the whole block. A sticky flag in the top bit of the seconds byte tells software that the time has not been set since the last reset, so the time must not be trusted.

Top module: `rtc_calendar_core`

## Requirements
- R1: The register map is: control at 0x0, seconds 0x2, minutes 0x3, hours 0x4, day 0x5, weekday 0x6, month 0x7, year 0x8. Every other address reads 0x00. Bits above each field's width read 0: seconds and minutes use 7 bits, hours and day 6, weekday 3, month 5, year 8.
- R2: The seconds advance once for every `TICK_DIV` tick pulses. A write to any of the addresses 0x2 to 0x8 restarts the prescaler count from zero. Without tick pulses the time does not change.
- R3: Seconds wrap from 0x59 to 0x00 and carry into the minutes. Minutes wrap from 0x59 to 0x00 and carry into the hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: While bit 5 of the control byte is 1, no field changes and the prescaler holds. Clearing the bit resumes counting from the held prescaler value.
- R5: A control write whose bits 3, 4 and 6 are all 1 resets the block, the same as the reset pin: time 00:00:00, day 0x01, weekday 0, month 0x01, year 0x00, control byte 0x00, prescaler 0, stopped-flag set.
- R6: Bit 7 of the seconds byte is the stopped-flag. It is set by reset. Any write to address 0x2 clears it. No other write and no counting changes it.
- R7: After the last day of a month, the day returns to 0x01 and the month increments. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, months 4, 6, 9 and 11 have 30, and February has 28.
- R8: February has 29 days when the BCD year is a multiple of four, and 00 counts as one.
- R9: Month 0x12 rolls to 0x01 and increments the year. The year wraps from 0x99 to 0x00.
- R10: The weekday steps on every day change and wraps from 6 to 0.
- R11: When control bit 2 is 1, the hours byte reads and writes as BCD 1 to 12 in bits 4:0 with bit 5 = PM. Hour 0 is 12 AM and hour 12 is 12 PM. Counting stays in 24-hour form.
- R12: The control byte stores only bit 5 (stop) and bit 2 (12-hour). All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-rate pulse feeding the sub-second prescaler |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr` (combinational) |

## Verification
The bench loads calendar values that sit one second before a rollover: end of a minute, of a day, of a 30-day and a 31-day month, of February in leap and common years, and of the century. A wrong carry chain or month-length table shows up there as a skipped or extra day, or as a year that never moves. It runs partial prescaler counts around writes and around the stop bit. A block that did not restart the prescaler on time writes, or that kept counting while stopped, would advance a second early or drift. It also checks the 12-hour hour conversion at midnight and noon, where an off-by-twelve is most likely. Finally it checks that the stopped-flag survives writes to the other fields and that the soft-reset pattern is the only control value that resets.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Register addresses (the time fields are contiguous from FIELD_BASE)
  localparam int ADDR_CTRL  = 0;
  localparam int FIELD_BASE = 2;
  localparam int NUM_FIELDS = 7;

  // Field index inside the time block
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  // Control byte bits
  localparam int CTRL_STOP_BIT = 5;
  localparam int CTRL_H12_BIT  = 2;
  localparam logic [7:0] SOFT_RST_MASK = 8'h58;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_FIELDS-1:0] fieldWr;
    logic                  advance;
    logic                  softReset;
    logic                  mode12;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // BCD year divisible by four
  function automatic logic isLeap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // Last day of a BCD month, as BCD
  function automatic logic [5:0] lastDay(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One BCD counting field: loadable, wraps to LOW_VAL above maxVal.
module rtc_bcd_field import rtc_cal_pkg::*; #(
  parameter int W       = 7,
  parameter int LOW_VAL = 0,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  input  logic [W-1:0] maxVal,
  output logic [W-1:0] value,
  output logic         carry
);

  localparam logic [W-1:0] LOW_W = W'(LOW_VAL);
  localparam logic [W-1:0] RST_W = W'(RST_VAL);

  logic [7:0] stepped;

  assign carry   = inc && (value >= maxVal);
  assign stepped = bcdInc(8'(value));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      value <= RST_W;
    else if (clear) value <= RST_W;
    else if (load)  value <= loadVal;
    else if (inc)   value <= carry ? LOW_W : stepped[W-1:0];
  end

endmodule

// File: rtl/rtc_cal_ctrl.sv
// Address decode, control byte, soft reset detection and prescaler.
module rtc_cal_ctrl import rtc_cal_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output calStrobe_t        stb,
  output logic [7:0]        ctrlByte
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic                  stopBit;
  logic                  mode12Bit;
  logic [PW-1:0]         preCnt;
  logic [NUM_FIELDS-1:0] fieldHit;
  logic                  timeWr;
  logic                  ctrlWr;
  logic                  softRst;
  logic                  rollOver;

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
      assign fieldHit[i] = wrEn && (addr == ADDR_W'(FIELD_BASE + i));
    end
  endgenerate

  assign timeWr   = |fieldHit;
  assign ctrlWr   = wrEn && (addr == ADDR_W'(ADDR_CTRL));
  assign softRst  = ctrlWr && ((wrData & SOFT_RST_MASK) == SOFT_RST_MASK);
  assign rollOver = tick && !stopBit && (preCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBit   <= 1'b0;
      mode12Bit <= 1'b0;
      preCnt    <= '0;
    end else if (softRst) begin
      stopBit   <= 1'b0;
      mode12Bit <= 1'b0;
      preCnt    <= '0;
    end else begin
      if (ctrlWr) begin
        stopBit   <= wrData[CTRL_STOP_BIT];
        mode12Bit <= wrData[CTRL_H12_BIT];
      end
      if (timeWr)                preCnt <= '0;
      else if (tick && !stopBit) preCnt <= rollOver ? '0 : preCnt + PW'(1);
    end
  end

  always_comb begin
    stb.fieldWr   = fieldHit;
    stb.advance   = rollOver && !timeWr;
    stb.softReset = softRst;
    stb.mode12    = mode12Bit;
    ctrlByte      = 8'h00;
    ctrlByte[CTRL_STOP_BIT] = stopBit;
    ctrlByte[CTRL_H12_BIT]  = mode12Bit;
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
// Calendar fields, carry chain, hour format conversion and read mux.
module rtc_cal_datapath import rtc_cal_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        ctrlByte,
  output logic [7:0]        rdData
);

  logic [6:0] secVal, minVal;
  logic [5:0] hourVal, dayVal;
  logic [4:0] monVal;
  logic [7:0] yearVal;
  logic [2:0] wdayVal;
  logic       osfFlag;
  logic       secCarry, minCarry, hourCarry, dayCarry, monCarry, yearCarry;
  logic [5:0] dayMax;
  logic [5:0] hourLoad;
  logic [7:0] hourRead;

  assign dayMax = lastDay(monVal, isLeap(yearVal));

  // Hour write path: 12-hour input folded to 24-hour BCD
  always_comb begin
    logic [6:0] hv;
    logic [6:0] h24;
    logic [7:0] enc;
    hv  = bcd2bin({3'b000, wrData[4:0]});
    if (hv == 7'd12) h24 = wrData[5] ? 7'd12 : 7'd0;
    else             h24 = wrData[5] ? hv + 7'd12 : hv;
    enc = bin2bcd(h24);
    hourLoad = stb.mode12 ? enc[5:0] : wrData[5:0];
  end

  // Hour read path
  always_comb begin
    logic [6:0] hb;
    logic [6:0] h12;
    logic       pm;
    logic [7:0] enc;
    hb = bcd2bin({2'b00, hourVal});
    if (hb == 7'd0)       begin h12 = 7'd12;       pm = 1'b0; end
    else if (hb < 7'd12)  begin h12 = hb;          pm = 1'b0; end
    else if (hb == 7'd12) begin h12 = 7'd12;       pm = 1'b1; end
    else                  begin h12 = hb - 7'd12;  pm = 1'b1; end
    enc = bin2bcd(h12);
    hourRead = stb.mode12 ? {2'b00, pm, enc[4:0]} : {2'b00, hourVal};
  end

  rtc_bcd_field #(.W(7), .LOW_VAL(0), .RST_VAL(0)) u_sec (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_SEC]),
    .loadVal(wrData[6:0]), .inc(stb.advance), .maxVal(7'h59),
    .value(secVal), .carry(secCarry));

  rtc_bcd_field #(.W(7), .LOW_VAL(0), .RST_VAL(0)) u_min (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_MIN]),
    .loadVal(wrData[6:0]), .inc(secCarry), .maxVal(7'h59),
    .value(minVal), .carry(minCarry));

  rtc_bcd_field #(.W(6), .LOW_VAL(0), .RST_VAL(0)) u_hour (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_HOUR]),
    .loadVal(hourLoad), .inc(minCarry), .maxVal(6'h23),
    .value(hourVal), .carry(hourCarry));

  rtc_bcd_field #(.W(6), .LOW_VAL(1), .RST_VAL(1)) u_day (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_DAY]),
    .loadVal(wrData[5:0]), .inc(hourCarry), .maxVal(dayMax),
    .value(dayVal), .carry(dayCarry));

  rtc_bcd_field #(.W(5), .LOW_VAL(1), .RST_VAL(1)) u_mon (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_MON]),
    .loadVal(wrData[4:0]), .inc(dayCarry), .maxVal(5'h12),
    .value(monVal), .carry(monCarry));

  rtc_bcd_field #(.W(8), .LOW_VAL(0), .RST_VAL(0)) u_year (
    .clk(clk), .rstN(rstN), .clear(stb.softReset), .load(stb.fieldWr[F_YEAR]),
    .loadVal(wrData), .inc(monCarry), .maxVal(8'h99),
    .value(yearVal), .carry(yearCarry));

  // Weekday (binary 0..6) and the sticky stopped-flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdayVal <= 3'd0;
      osfFlag <= 1'b1;
    end else if (stb.softReset) begin
      wdayVal <= 3'd0;
      osfFlag <= 1'b1;
    end else begin
      if (stb.fieldWr[F_WDAY]) wdayVal <= wrData[2:0];
      else if (hourCarry)      wdayVal <= (wdayVal >= 3'd6) ? 3'd0 : wdayVal + 3'd1;
      if (stb.fieldWr[F_SEC])  osfFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    case (int'(addr))
      ADDR_CTRL:           rdData = ctrlByte;
      FIELD_BASE + F_SEC:  rdData = {osfFlag, secVal};
      FIELD_BASE + F_MIN:  rdData = {1'b0, minVal};
      FIELD_BASE + F_HOUR: rdData = hourRead;
      FIELD_BASE + F_DAY:  rdData = {2'b00, dayVal};
      FIELD_BASE + F_WDAY: rdData = {5'b00000, wdayVal};
      FIELD_BASE + F_MON:  rdData = {3'b000, monVal};
      FIELD_BASE + F_YEAR: rdData = yearVal;
      default:             rdData = 8'h00;
    endcase
  end

  logic unusedCarry;
  assign unusedCarry = yearCarry;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core import rtc_cal_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  calStrobe_t stb;
  logic [7:0] ctrlByte;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .stb(stb), .ctrlByte(ctrlByte));

  rtc_cal_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .ctrlByte(ctrlByte), .rdData(rdData));

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        ctrlByte,
  input logic              advance,
  input logic [6:0]        secVal,
  input logic [6:0]        minVal,
  input logic              osfFlag
);

  assert_osf_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=> !osfFlag);

  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0) && wrData[3] && wrData[4] && wrData[6])
      |=> (osfFlag && secVal == 7'h00 && minVal == 7'h00 && ctrlByte == 8'h00));

  assert_stop_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[5] && !wrEn) |=> ($stable(secVal) && $stable(minVal)));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && secVal == 7'h59) |=> (secVal == 7'h00));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> ($stable(secVal) && $stable(minVal)));

endmodule

bind rtc_calendar_core rtc_cal_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .ctrlByte(ctrlByte), .advance(stb.advance),
  .secVal(u_dp.secVal), .minVal(u_dp.minVal), .osfFlag(u_dp.osfFlag));

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;

  localparam int ADDR_W   = 4;
  localparam int TICK_DIV = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wrData = 8'h00;
  logic [7:0]        rdData;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model (binary values)
  int ms, mm, mh, md, mwd, mmo, my, pcnt;
  bit mosf, mstop, mh12;

  rtc_calendar_core #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) u_rtc_calendar_core (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int hourEnc(int h, bit h12);
    int v;
    bit pm;
    if (!h12) return bcd(h);
    pm = (h >= 12);
    v  = h % 12;
    if (v == 0) v = 12;
    return (int'(pm) << 5) | bcd(v);
  endfunction

  task automatic modelReset();
    ms = 0; mm = 0; mh = 0; md = 1; mwd = 0; mmo = 1; my = 0;
    pcnt = 0; mosf = 1; mstop = 0; mh12 = 0;
  endtask

  task automatic modelSecond();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; md++;
          mwd = (mwd == 6) ? 0 : mwd + 1;
          if (md > mlen(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my = (my + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check(string tag, int got, int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 v = int'(rdData);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (!mstop) begin
        pcnt++;
        if (pcnt == TICK_DIV) begin
          pcnt = 0;
          modelSecond();
        end
      end
    end
  endtask

  task automatic wrCtrl(int d);
    wr(0, d);
    if ((d & 8'h58) == 8'h58) modelReset();
    else begin
      mstop = d[5];
      mh12  = d[2];
    end
  endtask

  task automatic setTime(int s, int m, int h, int d, int wd, int mo, int y);
    ms = s; mm = m; mh = h; md = d; mwd = wd; mmo = mo; my = y;
    wr(2, bcd(s)); wr(3, bcd(m)); wr(4, hourEnc(h, mh12));
    wr(5, bcd(d)); wr(6, wd); wr(7, bcd(mo)); wr(8, bcd(y));
    mosf = 0; pcnt = 0;
  endtask

  task automatic checkAll(string tag);
    int v;
    rd(2, v); check({tag, " sec"},  v, (int'(mosf) << 7) | bcd(ms));
    rd(3, v); check({tag, " min"},  v, bcd(mm));
    rd(4, v); check({tag, " hour"}, v, hourEnc(mh, mh12));
    rd(5, v); check({tag, " day"},  v, bcd(md));
    rd(6, v); check({tag, " wday"}, v, mwd);
    rd(7, v); check({tag, " mon"},  v, bcd(mmo));
    rd(8, v); check({tag, " year"}, v, bcd(my));
  endtask

  initial begin
    int v;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state, flag set (R5, R6) and unmapped addresses (R1)
    checkAll("R5 reset");
    rd(0, v); check("R12 ctrl reset", v, 0);
    rd(1, v); check("R1 addr 0x1", v, 0);
    rd(9, v); check("R1 addr 0x9", v, 0);
    rd(15, v); check("R1 addr 0xF", v, 0);

    // Flag survives other writes, clears on seconds write (R6)
    wr(3, 8'h15); mm = 15; pcnt = 0;
    rd(2, v); check("R6 flag kept after min write", v, 8'h80);
    setTime(10, 20, 5, 14, 3, 6, 21);
    checkAll("R6 after set");

    // Prescaler count (R2)
    ticks(TICK_DIV - 1);
    checkAll("R2 partial");
    wr(3, bcd(20)); pcnt = 0;
    ticks(TICK_DIV - 1);
    checkAll("R2 restart on write");
    ticks(1);
    checkAll("R2 one second");

    // Stop freezes (R4)
    wrCtrl(8'h20);
    ticks(TICK_DIV * 3);
    checkAll("R4 stopped");
    wrCtrl(8'h00);
    ticks(TICK_DIV * 2);
    checkAll("R4 resumed");

    // Control readback (R12) and a non-reset pattern
    wrCtrl(8'hA7);
    rd(0, v); check("R12 ctrl stored bits", v, 8'h24);
    checkAll("R12 no reset");
    wrCtrl(8'h00);

    // Rollovers
    setTime(59, 59, 23, 30, 6, 4, 22);  ticks(TICK_DIV); checkAll("R7 Apr30 R10 wrap");
    setTime(59, 59, 23, 31, 2, 1, 22);  ticks(TICK_DIV); checkAll("R7 Jan31");
    setTime(59, 59, 23, 28, 1, 2, 23);  ticks(TICK_DIV); checkAll("R7 Feb28 common");
    setTime(59, 59, 23, 28, 1, 2, 24);  ticks(TICK_DIV); checkAll("R8 Feb28 leap");
    ticks(TICK_DIV * 86400 / 86400);    checkAll("R8 Feb29 +1s");
    setTime(59, 59, 23, 29, 4, 2, 0);   ticks(TICK_DIV); checkAll("R8 Feb29 year00");
    setTime(59, 59, 23, 31, 5, 12, 99); ticks(TICK_DIV); checkAll("R9 century");
    setTime(59, 59, 23, 31, 0, 12, 37); ticks(TICK_DIV); checkAll("R9 Dec31");
    setTime(59, 59, 9, 3, 0, 3, 11);    ticks(TICK_DIV); checkAll("R3 hour carry");

    // 12-hour mode (R11)
    wrCtrl(8'h04);
    setTime(59, 59, 23, 5, 2, 5, 30);   ticks(TICK_DIV); checkAll("R11 midnight");
    setTime(59, 59, 11, 5, 2, 5, 30);   ticks(TICK_DIV); checkAll("R11 noon");
    setTime(0, 0, 17, 5, 2, 5, 30);     checkAll("R11 pm write");
    wrCtrl(8'h00);
    checkAll("R11 back to 24h");

    // Random near-rollover scenarios
    for (int it = 0; it < 60; it++) begin
      int s, m, h, mo, y, d;
      wrCtrl(($urandom % 2) ? 8'h04 : 8'h00);
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      d  = ($urandom % 2) ? mlen(mo, y) : 1 + $urandom % mlen(mo, y);
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      m  = ($urandom % 2) ? 59 : $urandom % 60;
      s  = 50 + $urandom % 10;
      setTime(s, m, h, d, $urandom % 7, mo, y);
      ticks($urandom % (TICK_DIV * 12));
      checkAll("R3 random");
    end

    // Soft reset (R5)
    wrCtrl(8'h24);
    setTime(33, 44, 15, 9, 4, 8, 45);
    ticks(2);
    wrCtrl(8'h58);
    checkAll("R5 soft reset");
    rd(0, v); check("R5 ctrl cleared", v, 0);
    ticks(TICK_DIV);
    checkAll("R5 counts after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule